// File: doc/BRIEF.md
# Source Path-Setup Handshake Sequencer

This block is the per-node interface controller for circuit-switched transfers across a mesh. A local client offers a message request carrying a destination node address. The sequencer sends a path-setup control packet toward the control router. It then waits for one of two single-bit sideband strobes: an acknowledgment that the path is in place, or a path-blocked notification. After an acknowledgment it holds the payload-modulator enable for the whole message and then pulses a teardown strobe that releases the path. After a blocked notification it waits a programmable number of cycles and sends the same setup packet again. It allows one transfer at a time.

The same block also acts as the far end of a transfer. When a setup packet addressed to the local node arrives from the router, it answers with a one-cycle acknowledgment strobe. The optical modulators and detectors are modelled as digital enable and strobe pins. Routing inside the mesh is not part of the block.

The request input and the setup-packet output are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A setup packet is offered with `setup_valid`, and its address stays unchanged until the router raises `setup_ready`.

Top module: `pxfer_nic`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `setup_valid`, `mod_en`, `beat_last`, `teardown_out`, `ack_out` and `proto_err` are 0.
- R2: A request is accepted only in a cycle with `req_valid` and `req_ready` both high. From the next cycle `req_ready` stays 0 until the transfer has ended, so a request offered while busy is not taken.
- R3: `setup_valid` rises in the cycle after a request is accepted, with `setup_dest` equal to the accepted `req_dest`. It and the address stay unchanged while `setup_ready` is low. It drops in the cycle after the handshake.
- R4: `mod_en` stays 0 while an answer is awaited. It rises in the cycle after an `ack_in` strobe that arrives while an answer is awaited.
- R5: `mod_en` stays high for exactly MSG_BYTES*8/BEAT_W consecutive cycles, one cycle per beat. `beat_last` is 1 only in the final one of those cycles. With the default 2048-byte message and 32-bit beats this is 512 cycles.
- R6: `teardown_out` is a single-cycle pulse in the cycle right after the last beat. `req_ready` returns to 1 in the following cycle.
- R7: A `blocked_in` strobe while an answer is awaited produces no `mod_en`. `setup_valid` is then 0 for exactly B+1 cycles, where B is the value of `backoff_cycles` in the cycle of the strobe. After that, `setup_valid` rises again with the same destination. Retries have no limit.
- R8: If `ack_in` and `blocked_in` arrive in the same waiting cycle, the acknowledgment wins and payload transmission starts.
- R9: An `ack_in` outside the waiting state starts no payload. It sets `proto_err`, which then stays 1 until reset.
- R10: A `blocked_in` outside the waiting state is ignored: `req_ready` stays 1 in idle, no setup is issued and `proto_err` is unchanged.
- R11: When `rx_setup_valid` is high and `rx_setup_dest` equals `my_node`, `ack_out` pulses for one cycle in the next cycle. An arriving setup for any other address produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_node | input | ADDR_W | Address of this node |
| backoff_cycles | input | BACKOFF_W | Retry wait; a blocked strobe gives a gap of this value plus one cycle |
| req_valid | input | 1 | Message request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_dest | input | ADDR_W | Destination address of the request |
| setup_valid | output | 1 | Setup packet offered to the control router |
| setup_ready | input | 1 | Router takes the setup packet |
| setup_dest | output | ADDR_W | Destination carried by the setup packet |
| ack_in | input | 1 | Path acknowledgment strobe from the destination |
| blocked_in | input | 1 | Path-blocked notification strobe |
| mod_en | output | 1 | Payload-modulator enable, one cycle per beat |
| beat_last | output | 1 | Marks the final payload beat |
| teardown_out | output | 1 | Path-release strobe |
| rx_setup_valid | input | 1 | A setup packet arrives from the router |
| rx_setup_dest | input | ADDR_W | Destination field of the arriving setup packet |
| ack_out | output | 1 | Acknowledgment strobe returned to a remote source |
| proto_err | output | 1 | Sticky flag set by an unexpected acknowledgment |

## Verification
The assertions check on every cycle the rules that relate neighbouring cycles:
- no request is taken while a transfer is in flight;
- the setup packet stays stable under back-pressure;
- the modulator enable starts only after an acknowledgment and runs for exactly the beat count, with the teardown right after it;
- the error flag stays set once raised;
- the returned acknowledgment follows each setup packet addressed to this node.

The retry gap depends on the backoff value sampled at the blocked strobe, so only the bench scenarios show it: they sweep that value and compare the measured gap with value plus one. The same holds for the choice when both strobes arrive together, for strobes arriving in idle, and for setup packets addressed to every node address.

// File: rtl/pxfer_pkg.sv
`timescale 1ns/1ps
package pxfer_pkg;
  typedef enum logic [2:0] {
    XS_IDLE    = 3'd0,
    XS_SETUP   = 3'd1,
    XS_WAIT    = 3'd2,
    XS_XMIT    = 3'd3,
    XS_TDOWN   = 3'd4,
    XS_BACKOFF = 3'd5
  } xfer_state_e;
endpackage

// File: rtl/pxfer_dncnt.sv
`timescale 1ns/1ps
module pxfer_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         is_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  assign is_zero = (count == '0);
endmodule

// File: rtl/pxfer_dest_ack.sv
`timescale 1ns/1ps
module pxfer_dest_ack #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_node,
  input  logic              rx_setup_valid,
  input  logic [ADDR_W-1:0] rx_setup_dest,
  output logic              ack_out
);
  logic hit;
  assign hit = rx_setup_valid && (rx_setup_dest == my_node);

  always_ff @(posedge clk) begin
    if (!rst_n) ack_out <= 1'b0;
    else        ack_out <= hit;
  end
endmodule

// File: rtl/pxfer_src_fsm.sv
`timescale 1ns/1ps
module pxfer_src_fsm
  import pxfer_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MSG_BYTES = 2048,
  parameter int BEAT_W    = 32,
  parameter int BACKOFF_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BACKOFF_W-1:0] backoff_cycles,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_dest,
  output logic                 setup_valid,
  input  logic                 setup_ready,
  output logic [ADDR_W-1:0]    setup_dest,
  input  logic                 ack_in,
  input  logic                 blocked_in,
  output logic                 mod_en,
  output logic                 beat_last,
  output logic                 teardown_out,
  output logic                 proto_err
);
  localparam int BEATS = (MSG_BYTES * 8) / BEAT_W;
  localparam int BC_W  = $clog2(BEATS + 1);

  xfer_state_e state, nxt;
  logic [ADDR_W-1:0] dest_q;
  logic [BC_W-1:0]   beat_cnt;
  logic              beat_zero;
  logic [BACKOFF_W-1:0] bo_cnt;
  logic              bo_zero;
  logic              in_wait;
  logic              take_req;

  assign in_wait  = (state == XS_WAIT);
  assign take_req = (state == XS_IDLE) && req_valid;

  pxfer_dncnt #(.W(BC_W)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_wait && ack_in),
    .load_val (BC_W'(BEATS)),
    .dec      (state == XS_XMIT),
    .count    (beat_cnt),
    .is_zero  (beat_zero)
  );

  pxfer_dncnt #(.W(BACKOFF_W)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_wait && !ack_in && blocked_in),
    .load_val (backoff_cycles),
    .dec      (state == XS_BACKOFF),
    .count    (bo_cnt),
    .is_zero  (bo_zero)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      XS_IDLE:    if (req_valid)   nxt = XS_SETUP;
      XS_SETUP:   if (setup_ready) nxt = XS_WAIT;
      XS_WAIT: begin
        if (ack_in)          nxt = XS_XMIT;
        else if (blocked_in) nxt = XS_BACKOFF;
      end
      XS_XMIT:    if (beat_cnt == BC_W'(1)) nxt = XS_TDOWN;
      XS_TDOWN:   nxt = XS_IDLE;
      XS_BACKOFF: if (bo_zero) nxt = XS_SETUP;
      default:    nxt = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      dest_q    <= '0;
      proto_err <= 1'b0;
    end else begin
      state <= nxt;
      if (take_req) dest_q <= req_dest;
      if (ack_in && !in_wait) proto_err <= 1'b1;
    end
  end

  assign req_ready    = (state == XS_IDLE);
  assign setup_valid  = (state == XS_SETUP);
  assign setup_dest   = dest_q;
  assign mod_en       = (state == XS_XMIT) && !beat_zero;
  assign beat_last    = mod_en && (beat_cnt == BC_W'(1));
  assign teardown_out = (state == XS_TDOWN);

  logic unused_bo;
  assign unused_bo = ^bo_cnt;
endmodule

// File: rtl/pxfer_nic.sv
`timescale 1ns/1ps
module pxfer_nic #(
  parameter int ADDR_W    = 4,
  parameter int MSG_BYTES = 2048,
  parameter int BEAT_W    = 32,
  parameter int BACKOFF_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    my_node,
  input  logic [BACKOFF_W-1:0] backoff_cycles,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_dest,
  output logic                 setup_valid,
  input  logic                 setup_ready,
  output logic [ADDR_W-1:0]    setup_dest,
  input  logic                 ack_in,
  input  logic                 blocked_in,
  output logic                 mod_en,
  output logic                 beat_last,
  output logic                 teardown_out,
  input  logic                 rx_setup_valid,
  input  logic [ADDR_W-1:0]    rx_setup_dest,
  output logic                 ack_out,
  output logic                 proto_err
);
  pxfer_src_fsm #(
    .ADDR_W    (ADDR_W),
    .MSG_BYTES (MSG_BYTES),
    .BEAT_W    (BEAT_W),
    .BACKOFF_W (BACKOFF_W)
  ) u_src (
    .clk            (clk),
    .rst_n          (rst_n),
    .backoff_cycles (backoff_cycles),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_dest       (req_dest),
    .setup_valid    (setup_valid),
    .setup_ready    (setup_ready),
    .setup_dest     (setup_dest),
    .ack_in         (ack_in),
    .blocked_in     (blocked_in),
    .mod_en         (mod_en),
    .beat_last      (beat_last),
    .teardown_out   (teardown_out),
    .proto_err      (proto_err)
  );

  pxfer_dest_ack #(.ADDR_W(ADDR_W)) u_dst (
    .clk            (clk),
    .rst_n          (rst_n),
    .my_node        (my_node),
    .rx_setup_valid (rx_setup_valid),
    .rx_setup_dest  (rx_setup_dest),
    .ack_out        (ack_out)
  );
endmodule

// File: rtl/pxfer_nic_chk.sv
`timescale 1ns/1ps
module pxfer_nic_chk #(
  parameter int ADDR_W    = 4,
  parameter int MSG_BYTES = 2048,
  parameter int BEAT_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] my_node,
  input logic              req_ready,
  input logic              setup_valid,
  input logic              setup_ready,
  input logic [ADDR_W-1:0] setup_dest,
  input logic              ack_in,
  input logic              mod_en,
  input logic              beat_last,
  input logic              teardown_out,
  input logic              rx_setup_valid,
  input logic [ADDR_W-1:0] rx_setup_dest,
  input logic              ack_out,
  input logic              proto_err
);
  localparam int BEATS = (MSG_BYTES * 8) / BEAT_W;
  localparam int RL_W  = $clog2(BEATS + 2);

  logic [RL_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)       run_len <= '0;
    else if (mod_en)  run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(setup_valid || mod_en || teardown_out));

  assert_setup_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && !setup_ready) |=> (setup_valid && $stable(setup_dest)));

  assert_mod_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_en) |-> $past(ack_in));

  assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> (mod_en && (run_len == RL_W'(BEATS - 1))));

  assert_teardown_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_en) |-> teardown_out);

  assert_teardown_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    teardown_out |=> (!teardown_out && req_ready));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_err_on_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && req_ready) |=> proto_err);

  assert_dest_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_setup_valid && (rx_setup_dest == my_node)) |=> ack_out);

  assert_dest_ack_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> $past(rx_setup_valid));
endmodule

bind pxfer_nic pxfer_nic_chk #(
  .ADDR_W    (ADDR_W),
  .MSG_BYTES (MSG_BYTES),
  .BEAT_W    (BEAT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .my_node        (my_node),
  .req_ready      (req_ready),
  .setup_valid    (setup_valid),
  .setup_ready    (setup_ready),
  .setup_dest     (setup_dest),
  .ack_in         (ack_in),
  .mod_en         (mod_en),
  .beat_last      (beat_last),
  .teardown_out   (teardown_out),
  .rx_setup_valid (rx_setup_valid),
  .rx_setup_dest  (rx_setup_dest),
  .ack_out        (ack_out),
  .proto_err      (proto_err)
);

// File: tb/sim_pxfer_nic.sv
`timescale 1ns/1ps
module sim_pxfer_nic;
  localparam int ADDR_W    = 4;
  localparam int MSG_BYTES = 16;
  localparam int BEAT_W    = 32;
  localparam int BACKOFF_W = 4;
  localparam int BEATS     = (MSG_BYTES * 8) / BEAT_W;
  localparam int MYN       = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] my_node = ADDR_W'(MYN);
  logic [BACKOFF_W-1:0] backoff_cycles = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_dest = '0;
  logic setup_valid;
  logic setup_ready = 1'b0;
  logic [ADDR_W-1:0] setup_dest;
  logic ack_in = 1'b0;
  logic blocked_in = 1'b0;
  logic mod_en, beat_last, teardown_out;
  logic rx_setup_valid = 1'b0;
  logic [ADDR_W-1:0] rx_setup_dest = '0;
  logic ack_out, proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pxfer_nic #(
    .ADDR_W(ADDR_W), .MSG_BYTES(MSG_BYTES), .BEAT_W(BEAT_W), .BACKOFF_W(BACKOFF_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .my_node(my_node), .backoff_cycles(backoff_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest),
    .setup_valid(setup_valid), .setup_ready(setup_ready), .setup_dest(setup_dest),
    .ack_in(ack_in), .blocked_in(blocked_in), .mod_en(mod_en), .beat_last(beat_last),
    .teardown_out(teardown_out), .rx_setup_valid(rx_setup_valid),
    .rx_setup_dest(rx_setup_dest), .ack_out(ack_out), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Payload phase: called at the negedge where ack has just been registered.
  task automatic drain_payload(input string tag);
    for (int i = 0; i < BEATS; i++) begin
      chk(mod_en == 1'b1, {tag, " R5 mod_en high"}, int'(mod_en), 1);
      chk(beat_last == (i == BEATS - 1), {tag, " R5 beat_last"}, int'(beat_last), int'(i == BEATS - 1));
      chk(teardown_out == 1'b0, {tag, " R6 no early teardown"}, int'(teardown_out), 0);
      tick();
    end
    chk(mod_en == 1'b0, {tag, " R5 mod_en ends"}, int'(mod_en), 0);
    chk(teardown_out == 1'b1, {tag, " R6 teardown pulse"}, int'(teardown_out), 1);
    tick();
    chk(teardown_out == 1'b0, {tag, " R6 teardown single"}, int'(teardown_out), 0);
    chk(req_ready == 1'b1, {tag, " R6 back to ready"}, int'(req_ready), 1);
  endtask

  task automatic full_xfer(input int dest, input int rdy_delay);
    req_dest  = ADDR_W'(dest);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready in idle", int'(req_ready), 1);
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    chk(setup_valid == 1'b1, "R3 setup offered", int'(setup_valid), 1);
    chk(int'(setup_dest) == dest, "R3 setup dest", int'(setup_dest), dest);
    for (int k = 0; k < rdy_delay; k++) begin
      tick();
      chk(setup_valid == 1'b1, "R3 setup held", int'(setup_valid), 1);
      chk(int'(setup_dest) == dest, "R3 dest stable", int'(setup_dest), dest);
    end
    setup_ready = 1'b1;
    tick();
    setup_ready = 1'b0;
    chk(setup_valid == 1'b0, "R3 setup dropped", int'(setup_valid), 0);
    req_dest  = ADDR_W'(dest ^ 1);
    req_valid = 1'b1;
    tick();
    chk(mod_en == 1'b0, "R4 no payload while waiting", int'(mod_en), 0);
    chk(req_ready == 1'b0, "R2 request held off", int'(req_ready), 0);
    chk(setup_valid == 1'b0, "R2 no second setup", int'(setup_valid), 0);
    req_valid = 1'b0;
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    drain_payload("xfer");
    chk(proto_err == 1'b0, "R9 no error in normal flow", int'(proto_err), 0);
  endtask

  task automatic blocked_xfer(input int dest, input int bo);
    int gap;
    req_dest  = ADDR_W'(dest);
    req_valid = 1'b1;
    tick();
    req_valid   = 1'b0;
    setup_ready = 1'b1;
    tick();
    setup_ready    = 1'b0;
    backoff_cycles = BACKOFF_W'(bo);
    blocked_in     = 1'b1;
    tick();
    blocked_in     = 1'b0;
    backoff_cycles = BACKOFF_W'(~bo);
    gap = 0;
    while (!setup_valid && gap < 40) begin
      chk(mod_en == 1'b0, "R7 no payload after blocked", int'(mod_en), 0);
      gap++;
      tick();
    end
    chk(gap == bo + 1, "R7 backoff gap", gap, bo + 1);
    chk(int'(setup_dest) == dest, "R7 retry dest", int'(setup_dest), dest);
    setup_ready = 1'b1;
    tick();
    setup_ready = 1'b0;
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    drain_payload("retry");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(setup_valid == 1'b0, "R1 reset setup_valid", int'(setup_valid), 0);
    chk(mod_en == 1'b0, "R1 reset mod_en", int'(mod_en), 0);
    rst_n = 1'b1;
    tick();
    chk(beat_last == 1'b0, "R1 beat_last", int'(beat_last), 0);
    chk(teardown_out == 1'b0, "R1 teardown", int'(teardown_out), 0);
    chk(ack_out == 1'b0, "R1 ack_out", int'(ack_out), 0);
    chk(proto_err == 1'b0, "R1 proto_err", int'(proto_err), 0);

    for (int d = 0; d < (1 << ADDR_W); d++) full_xfer(d, d % 4);

    for (int b = 0; b < (1 << BACKOFF_W); b++) blocked_xfer((b * 3) % (1 << ADDR_W), b);

    // R8: both strobes in the same waiting cycle
    req_dest = 4'd9; req_valid = 1'b1; tick();
    req_valid = 1'b0; setup_ready = 1'b1; tick();
    setup_ready = 1'b0; ack_in = 1'b1; blocked_in = 1'b1; tick();
    ack_in = 1'b0; blocked_in = 1'b0;
    chk(mod_en == 1'b1, "R8 ack wins", int'(mod_en), 1);
    drain_payload("R8");

    // R10: blocked strobe in idle
    blocked_in = 1'b1; tick();
    blocked_in = 1'b0;
    chk(req_ready == 1'b1, "R10 still idle", int'(req_ready), 1);
    chk(setup_valid == 1'b0, "R10 no setup", int'(setup_valid), 0);
    tick();
    chk(setup_valid == 1'b0, "R10 no late setup", int'(setup_valid), 0);
    chk(proto_err == 1'b0, "R10 no error", int'(proto_err), 0);

    // R11: destination responder over all addresses
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      rx_setup_dest = ADDR_W'(a); rx_setup_valid = 1'b1; tick();
      rx_setup_valid = 1'b0;
      chk(ack_out == (a == MYN), "R11 ack_out on match", int'(ack_out), int'(a == MYN));
      tick();
      chk(ack_out == 1'b0, "R11 ack_out single", int'(ack_out), 0);
    end

    // R9: acknowledgment in idle
    ack_in = 1'b1; tick();
    ack_in = 1'b0;
    chk(mod_en == 1'b0, "R9 idle ack no payload", int'(mod_en), 0);
    chk(proto_err == 1'b1, "R9 error set", int'(proto_err), 1);
    full_xfer_err_check();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic full_xfer_err_check();
    req_dest = 4'd3; req_valid = 1'b1; tick();
    req_valid = 1'b0; setup_ready = 1'b1; tick();
    setup_ready = 1'b0; ack_in = 1'b1; tick();
    ack_in = 1'b0;
    drain_payload("R9 after error");
    chk(proto_err == 1'b1, "R9 error sticky", int'(proto_err), 1);
  endtask
endmodule